// File: doc/BRIEF.md
# Processor system register file

This block keeps the control and status registers of a 32-bit processor core behind one indexed read port and one indexed write port. A 5-bit index selects the register. Writes are qualified by a strobe and by a debug flag. The debug flag lets a debugger set fields that normal software cannot set, and it keeps a stored value as written where normal software would have it altered.

The status word is held as separate flag bits. Those bits drive the execute and exception logic through dedicated outputs, and the block packs them into a 32-bit word on reads. Each index has its own write filter. Some indices return fixed identification constants. The remaining indices read as zero and ignore writes.

A synchronous reset loads the start-up state. The block also holds the program counter, which the sequencer can load through a separate port.

Top module: `sysreg_file`

## Requirements
- R1: A synchronous reset clears every register and then applies three values. The cause register becomes 0x0000FFF0, the program counter becomes 0xFFFFFFF0, and the non-maskable-pending flag becomes 1, so the status word reads 0x00008000.
- R2: The status word (index 5) uses this layout: zero flag bit 0, sign bit 1, overflow bit 2, carry bit 3, FP precision bit 4, FP underflow bit 5, FP overflow bit 6, FP zero-divide bit 7, FP invalid bit 8, FP reserved-operand bit 9, interrupt-disable bit 12, address-trap-enable bit 13, exception-pending bit 14, non-maskable-pending bit 15, and interrupt level in bits 19:16. The same flags appear on the flag outputs, with `fpf_o` ordered {reserved-operand, invalid, zero-divide, overflow, underflow, precision} from bit 5 down to bit 0.
- R3: A write to the status word (index 5) keeps only the bits in 0x000FF3FF. So does a write to either saved-status register (index 1 and index 3).
- R4: A write to the saved exception PC (index 0), the duplexed PC (index 2) or the address-trap register (index 25) stores the data with bit 0 forced to 0.
- R5: The cause register (index 4) reads the fatal code in bits 31:16 and the exception code in bits 15:0. A write changes it only while `dbg_i` is 1.
- R6: Index 6 reads 0x00005346, index 7 reads 0x000000E0 and index 30 reads 0x00000004. A write to any of them does not change what they read.
- R7: The cache-control register (index 24) stores only bit 1 of written data and reads it back at bit 1, with every other bit 0.
- R8: Index 31 holds different data depending on the write. A non-debug write of a negative value (bit 31 set) stores its two's-complement negation. Any other write stores the data unchanged. Index 29 always stores the data unchanged.
- R9: Indices 8 to 23 and 26 to 28 read zero, and writing them leaves them reading zero.
- R10: A read of an index in the same cycle as a write to that index returns the value held before the write.
- R11: When `pc_ld_i` is 1, the program counter takes `pc_nxt_i` at the next clock edge.
- R12: While `wr_en_i` is 0, no indexed register changes, whatever the index and data inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | 5 | Register index for the write |
| wr_data_i | input | 32 | Write data |
| dbg_i | input | 1 | Debug qualifier for the write |
| rd_idx_i | input | 5 | Register index for the read |
| rd_data_o | output | 32 | Read data (combinational) |
| pc_ld_i | input | 1 | Program counter load |
| pc_nxt_i | input | 32 | Program counter load value |
| pc_o | output | 32 | Program counter |
| flg_z_o | output | 1 | Zero flag |
| flg_s_o | output | 1 | Sign flag |
| flg_ov_o | output | 1 | Overflow flag |
| flg_cy_o | output | 1 | Carry flag |
| fpf_o | output | 6 | Floating-point flags |
| flg_id_o | output | 1 | Interrupt disable |
| flg_ae_o | output | 1 | Address trap enable |
| flg_ep_o | output | 1 | Exception pending |
| flg_np_o | output | 1 | Non-maskable pending |
| ilvl_o | output | 4 | Interrupt level |

## Verification
The bench builds the block with the package defaults: a 32-bit datapath and a 5-bit index. With these values all 32 indices can be addressed, and the sign bit of index 31 sits at bit 31, where the negation rule acts. The status-word layout is checked twice, once through the read port and once by rebuilding the word from the flag outputs, so a misplaced flag shows up on both paths. The default widths also place the constant registers and the unimplemented gaps at their fixed indices, which the bench probes directly.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
    localparam int XLEN  = 32;
    localparam int IDX_W = 5;
    localparam int NSLOT = 5;

    localparam logic [IDX_W-1:0] IX_SAVE_PC = 5'd0;
    localparam logic [IDX_W-1:0] IX_SAVE_ST = 5'd1;
    localparam logic [IDX_W-1:0] IX_DUP_PC  = 5'd2;
    localparam logic [IDX_W-1:0] IX_DUP_ST  = 5'd3;
    localparam logic [IDX_W-1:0] IX_CAUSE   = 5'd4;
    localparam logic [IDX_W-1:0] IX_STATUS  = 5'd5;
    localparam logic [IDX_W-1:0] IX_CPU_ID  = 5'd6;
    localparam logic [IDX_W-1:0] IX_TASK_CW = 5'd7;
    localparam logic [IDX_W-1:0] IX_CACHE   = 5'd24;
    localparam logic [IDX_W-1:0] IX_TRAP    = 5'd25;
    localparam logic [IDX_W-1:0] IX_SCR     = 5'd29;
    localparam logic [IDX_W-1:0] IX_FIXED30 = 5'd30;
    localparam logic [IDX_W-1:0] IX_ABS     = 5'd31;

    localparam logic [XLEN-1:0] ST_MASK   = 32'h000F_F3FF;
    localparam logic [XLEN-1:0] ADDR_MASK = 32'hFFFF_FFFE;
    localparam logic [XLEN-1:0] ID_CONST  = 32'h0000_5346;
    localparam logic [XLEN-1:0] TCW_CONST = 32'h0000_00E0;
    localparam logic [XLEN-1:0] C30_CONST = 32'h0000_0004;
    localparam logic [XLEN-1:0] RST_PC    = 32'hFFFF_FFF0;
    localparam logic [XLEN-1:0] RST_CAUSE = 32'h0000_FFF0;

    typedef struct packed {
        logic [3:0] ilvl;
        logic np, ep, ae, id;
        logic fro, fiv, fzd, fov, fud, fpr;
        logic cy, ov, s, z;
    } psw_t;

    localparam psw_t PSW_RST = '{ilvl: 4'd0, np: 1'b1, default: 1'b0};

    function automatic logic [XLEN-1:0] psw_pack(input psw_t p);
        return {12'd0, p.ilvl, p.np, p.ep, p.ae, p.id, 2'b00,
                p.fro, p.fiv, p.fzd, p.fov, p.fud, p.fpr,
                p.cy, p.ov, p.s, p.z};
    endfunction

    function automatic psw_t psw_unpack(input logic [XLEN-1:0] w);
        psw_t p;
        p.ilvl = w[19:16];
        p.np = w[15]; p.ep = w[14]; p.ae = w[13]; p.id = w[12];
        p.fro = w[9]; p.fiv = w[8]; p.fzd = w[7];
        p.fov = w[6]; p.fud = w[5]; p.fpr = w[4];
        p.cy = w[3]; p.ov = w[2]; p.s = w[1]; p.z = w[0];
        return p;
    endfunction

    function automatic logic [IDX_W-1:0] slot_idx(input int k);
        case (k)
            0:       return IX_SAVE_PC;
            1:       return IX_SAVE_ST;
            2:       return IX_DUP_PC;
            3:       return IX_DUP_ST;
            default: return IX_TRAP;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] slot_mask(input int k);
        return (k == 1 || k == 3) ? ST_MASK : ADDR_MASK;
    endfunction
endpackage

// File: rtl/sysreg_slot.sv
module sysreg_slot #(
    parameter int               W    = 32,
    parameter logic [W-1:0]     MASK = '1
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i)     q_o <= '0;
        else if (we_i) q_o <= wdata_i & MASK;
    end

    // R3 / R4: bits outside the filter never survive a write
    p_slot_filter_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        we_i |=> ((q_o & ~MASK) == '0 && q_o == ($past(wdata_i) & MASK)));
endmodule

// File: rtl/sysreg_psw.sv
module sysreg_psw import sysreg_pkg::*; (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            we_i,
    input  logic [XLEN-1:0] wdata_i,
    output psw_t            psw_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i)     psw_o <= PSW_RST;
        else if (we_i) psw_o <= psw_unpack(wdata_i);
    end

    p_psw_mask_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        we_i |=> psw_pack(psw_o) == ($past(wdata_i) & ST_MASK));

    p_psw_hold_r12: assert property (@(posedge clk_i) disable iff (rst_i)
        !we_i |=> $stable(psw_o));
endmodule

// File: rtl/sysreg_cause.sv
module sysreg_cause import sysreg_pkg::*; (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            we_i,
    input  logic            dbg_i,
    input  logic [XLEN-1:0] wdata_i,
    output logic [XLEN-1:0] q_o
);
    logic [15:0] fatal_code;
    logic [15:0] exc_code;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            fatal_code <= RST_CAUSE[31:16];
            exc_code   <= RST_CAUSE[15:0];
        end else if (we_i && dbg_i) begin
            fatal_code <= wdata_i[31:16];
            exc_code   <= wdata_i[15:0];
        end
    end

    assign q_o = {fatal_code, exc_code};

    p_cause_dbg_only_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (we_i && !dbg_i) |=> $stable(q_o));
endmodule

// File: rtl/sysreg_file.sv
module sysreg_file import sysreg_pkg::*; (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [XLEN-1:0]  wr_data_i,
    input  logic             dbg_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [XLEN-1:0]  rd_data_o,
    input  logic             pc_ld_i,
    input  logic [XLEN-1:0]  pc_nxt_i,
    output logic [XLEN-1:0]  pc_o,
    output logic             flg_z_o,
    output logic             flg_s_o,
    output logic             flg_ov_o,
    output logic             flg_cy_o,
    output logic [5:0]       fpf_o,
    output logic             flg_id_o,
    output logic             flg_ae_o,
    output logic             flg_ep_o,
    output logic             flg_np_o,
    output logic [3:0]       ilvl_o
);
    psw_t            psw_q;
    logic [XLEN-1:0] cause_q;
    logic [XLEN-1:0] slot_q [NSLOT];
    logic [XLEN-1:0] scr_q;
    logic [XLEN-1:0] abs_q;
    logic            cache_en_q;
    logic [XLEN-1:0] abs_wval;

    sysreg_psw u_psw (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .we_i    (wr_en_i && wr_idx_i == IX_STATUS),
        .wdata_i (wr_data_i),
        .psw_o   (psw_q)
    );

    sysreg_cause u_cause (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .we_i    (wr_en_i && wr_idx_i == IX_CAUSE),
        .dbg_i   (dbg_i),
        .wdata_i (wr_data_i),
        .q_o     (cause_q)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        sysreg_slot #(.W(XLEN), .MASK(slot_mask(g))) u_slot (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .we_i    (wr_en_i && wr_idx_i == slot_idx(g)),
            .wdata_i (wr_data_i),
            .q_o     (slot_q[g])
        );
    end

    assign abs_wval = (!dbg_i && wr_data_i[XLEN-1]) ? ('0 - wr_data_i) : wr_data_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            scr_q      <= '0;
            abs_q      <= '0;
            cache_en_q <= 1'b0;
            pc_o       <= RST_PC;
        end else begin
            if (wr_en_i && wr_idx_i == IX_SCR)   scr_q      <= wr_data_i;
            if (wr_en_i && wr_idx_i == IX_ABS)   abs_q      <= abs_wval;
            if (wr_en_i && wr_idx_i == IX_CACHE) cache_en_q <= wr_data_i[1];
            if (pc_ld_i)                         pc_o       <= pc_nxt_i;
        end
    end

    always_comb begin
        rd_data_o = '0;
        case (rd_idx_i)
            IX_CAUSE:   rd_data_o = cause_q;
            IX_STATUS:  rd_data_o = psw_pack(psw_q);
            IX_CPU_ID:  rd_data_o = ID_CONST;
            IX_TASK_CW: rd_data_o = TCW_CONST;
            IX_CACHE:   rd_data_o = {{(XLEN-2){1'b0}}, cache_en_q, 1'b0};
            IX_SCR:     rd_data_o = scr_q;
            IX_FIXED30: rd_data_o = C30_CONST;
            IX_ABS:     rd_data_o = abs_q;
            default: begin
                for (int k = 0; k < NSLOT; k++)
                    if (rd_idx_i == slot_idx(k)) rd_data_o = slot_q[k];
            end
        endcase
    end

    assign flg_z_o  = psw_q.z;
    assign flg_s_o  = psw_q.s;
    assign flg_ov_o = psw_q.ov;
    assign flg_cy_o = psw_q.cy;
    assign fpf_o    = {psw_q.fro, psw_q.fiv, psw_q.fzd, psw_q.fov, psw_q.fud, psw_q.fpr};
    assign flg_id_o = psw_q.id;
    assign flg_ae_o = psw_q.ae;
    assign flg_ep_o = psw_q.ep;
    assign flg_np_o = psw_q.np;
    assign ilvl_o   = psw_q.ilvl;

    p_reset_state_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (pc_o == RST_PC && flg_np_o && cause_q == RST_CAUSE && abs_q == '0));

    p_abs_store_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && wr_idx_i == IX_ABS && !dbg_i && wr_data_i[XLEN-1])
        |=> (abs_q + $past(wr_data_i)) == '0);

    p_cache_bit_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_idx_i == IX_CACHE) |-> (rd_data_o & ~32'h2) == '0);

    p_pc_load_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        pc_ld_i |=> pc_o == $past(pc_nxt_i));

    p_fixed_id_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_idx_i == IX_CPU_ID) |-> rd_data_o == ID_CONST);
endmodule

// File: tb/sysreg_file_tb.sv
`timescale 1ns/100ps
module sysreg_file_tb_top;
    localparam real CLK_NS = 4.0;

    logic        clk = 1'b0;
    logic        rst_i, wr_en_i, dbg_i, pc_ld_i;
    logic [4:0]  wr_idx_i, rd_idx_i;
    logic [31:0] wr_data_i, pc_nxt_i, rd_data_o, pc_o;
    logic        flg_z_o, flg_s_o, flg_ov_o, flg_cy_o, flg_id_o, flg_ae_o, flg_ep_o, flg_np_o;
    logic [5:0]  fpf_o;
    logic [3:0]  ilvl_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] q_exp [$];
    int          q_kind[$];
    string       q_tag [$];

    always #(CLK_NS/2) clk = ~clk;

    sysreg_file dut_i (
        .clk_i(clk), .rst_i(rst_i), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
        .wr_data_i(wr_data_i), .dbg_i(dbg_i), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o),
        .pc_ld_i(pc_ld_i), .pc_nxt_i(pc_nxt_i), .pc_o(pc_o),
        .flg_z_o(flg_z_o), .flg_s_o(flg_s_o), .flg_ov_o(flg_ov_o), .flg_cy_o(flg_cy_o),
        .fpf_o(fpf_o), .flg_id_o(flg_id_o), .flg_ae_o(flg_ae_o), .flg_ep_o(flg_ep_o),
        .flg_np_o(flg_np_o), .ilvl_o(ilvl_o)
    );

    // kind 0: read port, 1: status word rebuilt from flag outputs, 2: program counter
    function automatic logic [31:0] observe(input int kind);
        case (kind)
            1:       return {12'd0, ilvl_o, flg_np_o, flg_ep_o, flg_ae_o, flg_id_o, 2'b00,
                             fpf_o, flg_cy_o, flg_ov_o, flg_s_o, flg_z_o};
            2:       return pc_o;
            default: return rd_data_o;
        endcase
    endfunction

    // monitor: compares queued expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q_kind.size() > 0) begin
                logic [31:0] e, a;
                int k;
                string t;
                e = q_exp.pop_front();
                k = q_kind.pop_front();
                t = q_tag.pop_front();
                a = observe(k);
                n_cmp++;
                if (a !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", t, a, e);
                end
            end
        end
    end

    // driver tasks (called at a falling edge)
    task automatic expect_val(input int kind, input logic [4:0] idx, input logic [31:0] e, input string t);
        rd_idx_i = idx;
        q_exp.push_back(e);
        q_kind.push_back(kind);
        q_tag.push_back(t);
        @(negedge clk);
    endtask

    task automatic write_reg(input logic [4:0] idx, input logic [31:0] d, input logic dbg);
        wr_en_i = 1'b1; wr_idx_i = idx; wr_data_i = d; dbg_i = dbg;
        @(negedge clk);
        wr_en_i = 1'b0; dbg_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_i = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 50000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_i = 1'b1; wr_en_i = 1'b0; dbg_i = 1'b0; pc_ld_i = 1'b0;
        wr_idx_i = '0; rd_idx_i = '0; wr_data_i = '0; pc_nxt_i = '0;
        @(negedge clk);
        do_reset();

        // R1 reset state
        expect_val(0, 5'd5, 32'h0000_8000, "R1 status");
        expect_val(1, 5'd5, 32'h0000_8000, "R1 flags");
        expect_val(0, 5'd4, 32'h0000_FFF0, "R1 cause");
        expect_val(2, 5'd0, 32'hFFFF_FFF0, "R1 pc");
        expect_val(0, 5'd0, 32'h0, "R1 saved pc");

        // R2 / R3 status word layout and filter
        write_reg(5'd5, 32'hFFFF_FFFF, 1'b0);
        expect_val(0, 5'd5, 32'h000F_F3FF, "R3 status mask");
        expect_val(1, 5'd5, 32'h000F_F3FF, "R2 flags all");
        write_reg(5'd5, 32'h0005_1009, 1'b0);
        expect_val(1, 5'd5, 32'h0005_1009, "R2 flags pattern");
        write_reg(5'd5, 32'h0000_0AF0, 1'b0);
        expect_val(1, 5'd5, 32'h0000_02F0, "R2 fp flags");
        write_reg(5'd1, 32'hFFFF_FFFF, 1'b0);
        expect_val(0, 5'd1, 32'h000F_F3FF, "R3 saved status");
        write_reg(5'd3, 32'h1234_5678, 1'b0);
        expect_val(0, 5'd3, 32'h0004_5278, "R3 dup status");

        // R4 address registers
        write_reg(5'd0, 32'hFFFF_FFFF, 1'b0);
        expect_val(0, 5'd0, 32'hFFFF_FFFE, "R4 saved pc");
        write_reg(5'd2, 32'h1234_5679, 1'b0);
        expect_val(0, 5'd2, 32'h1234_5678, "R4 dup pc");
        write_reg(5'd25, 32'h0000_0003, 1'b0);
        expect_val(0, 5'd25, 32'h0000_0002, "R4 trap addr");

        // R5 cause register
        write_reg(5'd4, 32'hAAAA_5555, 1'b0);
        expect_val(0, 5'd4, 32'h0000_FFF0, "R5 non-debug ignored");
        write_reg(5'd4, 32'hAAAA_5555, 1'b1);
        expect_val(0, 5'd4, 32'hAAAA_5555, "R5 debug write");

        // R6 constants
        write_reg(5'd6, 32'hFFFF_FFFF, 1'b1);
        expect_val(0, 5'd6, 32'h0000_5346, "R6 id");
        expect_val(0, 5'd7, 32'h0000_00E0, "R6 task cw");
        write_reg(5'd30, 32'h0, 1'b0);
        expect_val(0, 5'd30, 32'h0000_0004, "R6 index30");

        // R7 cache control
        write_reg(5'd24, 32'hFFFF_FFFF, 1'b0);
        expect_val(0, 5'd24, 32'h0000_0002, "R7 enable set");
        write_reg(5'd24, 32'hFFFF_FFFD, 1'b0);
        expect_val(0, 5'd24, 32'h0000_0000, "R7 enable clear");

        // R8 index 31 and 29
        write_reg(5'd31, 32'hFFFF_FFF6, 1'b0);
        expect_val(0, 5'd31, 32'h0000_000A, "R8 negate");
        write_reg(5'd31, 32'hFFFF_FFF6, 1'b1);
        expect_val(0, 5'd31, 32'hFFFF_FFF6, "R8 debug raw");
        write_reg(5'd31, 32'h0000_0007, 1'b0);
        expect_val(0, 5'd31, 32'h0000_0007, "R8 positive");
        write_reg(5'd29, 32'h8000_0001, 1'b0);
        expect_val(0, 5'd29, 32'h8000_0001, "R8 index29 raw");

        // R9 unimplemented
        write_reg(5'd12, 32'hFFFF_FFFF, 1'b1);
        expect_val(0, 5'd12, 32'h0, "R9 index12");
        write_reg(5'd27, 32'hFFFF_FFFF, 1'b0);
        expect_val(0, 5'd27, 32'h0, "R9 index27");

        // R10 read during write returns the old value
        wr_en_i = 1'b1; wr_idx_i = 5'd29; wr_data_i = 32'h0000_0055;
        expect_val(0, 5'd29, 32'h8000_0001, "R10 old value");
        wr_en_i = 1'b0;
        expect_val(0, 5'd29, 32'h0000_0055, "R10 new value");

        // R12 strobe low: nothing changes
        wr_en_i = 1'b0; wr_idx_i = 5'd5; wr_data_i = 32'hFFFF_FFFF; dbg_i = 1'b1;
        @(negedge clk);
        wr_idx_i = 5'd4;
        @(negedge clk);
        dbg_i = 1'b0;
        expect_val(0, 5'd5, 32'h0000_02F0, "R12 status held");
        expect_val(0, 5'd4, 32'hAAAA_5555, "R12 cause held");

        // R11 program counter load
        pc_ld_i = 1'b1; pc_nxt_i = 32'h0000_1000;
        @(negedge clk);
        pc_ld_i = 1'b0;
        expect_val(2, 5'd0, 32'h0000_1000, "R11 pc load");

        // R1 reset mid-run
        do_reset();
        expect_val(0, 5'd5, 32'h0000_8000, "R1 status again");
        expect_val(0, 5'd4, 32'h0000_FFF0, "R1 cause again");
        expect_val(0, 5'd31, 32'h0, "R1 index31 cleared");
        expect_val(2, 5'd0, 32'hFFFF_FFF0, "R1 pc again");

        @(negedge clk);
        #2;
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule